// File: doc/BRIEF.md
# Disk Controller Register File and Command Decoder

This block is the register side of a moving-head disk controller. A host writes and reads seventeen 16-bit registers through a word select. It keeps the control word, drive status, attention summary, word count, bus address, sector/track and cylinder registers, plus ten plain storage words. Some status bits always read as 1. Writing the control register with its GO bit set starts a command.

Housekeeping commands finish at once: they set ready and, if interrupts are enabled, send a one-cycle interrupt request with a fixed level and vector. Transfer commands send a one-cycle start strobe to an external transfer engine. The strobe comes with the byte offset on the disk, worked out from the cylinder, track and sector registers. The 18-bit DMA start address is always on an output. When the engine signals completion, the block clears the word count, sets ready and sends an interrupt request if interrupts are enabled.

The interface has no data streams. Register access takes one cycle and the block never stalls it. Every pin is a plain control or status signal.

Top module: `dkc_regs`

## Requirements
- R1: Select values 0 to 16 address registers: 0 control, 1 drive status, 2 attention, 3 word count, 4 bus address, 5 sector/track, 6 cylinder, 7 to 16 plain storage. A write stores the word at the clock edge. The read value follows the select with no register delay. Reset clears every register to 0. Selects 17 to 31 read 0 and writes to them do nothing.
- R2: A read of the control register returns the stored word with ready (bit 7) forced to 1.
- R3: A read of drive status returns the stored word with bits 6, 7, 8 and 12 forced to 1, so the forcing mask is 16'h11C0.
- R4: A control write whose data has bit 7 set loads the attention register with 1. A control write with bit 7 clear leaves the attention register unchanged.
- R5: A control write with GO (bit 0) set stores the word with GO, the function field (bits 5:1) and transfer error (bit 14) cleared. All other written bits are kept, including interrupt enable (bit 6) and A16/A17 (bits 9:8).
- R6: Function codes octal 006, 012, 016, 020 and 022 (the full control word masked with octal 076) are housekeeping commands. They set stored ready and request an interrupt if the written interrupt enable bit is 1.
- R7: Function codes octal 050 and above are transfers. The cycle after the GO write, xfer_start is 1 for exactly one cycle and no interrupt is requested. Any other function code stores the word and does nothing else.
- R8: A cycle with xfer_done high sets the word count to 0 and stored ready to 1. It requests an interrupt if interrupt enable is 1.
- R9: dma_addr equals {control bit 9, control bit 8, bus address register}.
- R10: irq_req is high for one cycle, the cycle after its cause. irq_level is always 5 and irq_vector is always octal 0254. No request occurs while interrupt enable is 0.
- R11: The byte offset is ((cylinder × 19 + track) × 22 + sector) × 512. The cylinder comes from register 6 bits 9:0, the track from register 5 bits 12:8 and the sector from register 5 bits 4:0. byte_offset holds this value in the cycle xfer_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the selected register |
| reg_sel | input | 5 | Register select, shared by reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for reg_sel, combinational |
| xfer_done | input | 1 | Transfer engine completion pulse |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| byte_offset | output | 32 | Linear byte offset on the disk |
| dma_addr | output | 18 | DMA start address |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_level | output | 3 | Interrupt priority level |
| irq_vector | output | 9 | Interrupt vector |

## Verification
The attention, GO-clear and word-count properties take as given that a completion pulse never arrives in the same cycle as a host write to the word-count register. The bench meets this by pulsing xfer_done only while wr_en is low. The interrupt property takes as given that an enable change and its cause are seen together on the same edge. The bench therefore always carries the interrupt enable bit in the same control word as the GO bit.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int WORD_W    = 16;
  localparam int REG_COUNT = 17;
  localparam int SEL_W     = 5;

  localparam logic [SEL_W-1:0] SEL_CTRL   = 5'd0;
  localparam logic [SEL_W-1:0] SEL_DSTAT  = 5'd1;
  localparam logic [SEL_W-1:0] SEL_ATTN   = 5'd2;
  localparam logic [SEL_W-1:0] SEL_WCNT   = 5'd3;
  localparam logic [SEL_W-1:0] SEL_BADDR  = 5'd4;
  localparam logic [SEL_W-1:0] SEL_SECTRK = 5'd5;
  localparam logic [SEL_W-1:0] SEL_CYL    = 5'd6;
  localparam logic [SEL_W-1:0] SEL_LAST   = SEL_W'(REG_COUNT - 1);

  // control word bit positions
  localparam int CB_GO  = 0;
  localparam int CB_FNL = 1;
  localparam int CB_FNH = 5;
  localparam int CB_IE  = 6;
  localparam int CB_RDY = 7;
  localparam int CB_A16 = 8;
  localparam int CB_A17 = 9;
  localparam int CB_TRE = 14;

  localparam logic [WORD_W-1:0] CTRL_FORCE  = 16'h0080;
  localparam logic [WORD_W-1:0] DSTAT_FORCE = 16'h11C0;
  localparam logic [WORD_W-1:0] GO_CLEAR    = 16'h403F;

  typedef enum logic [1:0] {FK_OTHER, FK_NOOP, FK_XFER} fn_kind_e;
endpackage

// File: rtl/dkc_func_decode.sv
module dkc_func_decode
  import dkc_pkg::*;
#(
  parameter int XFER_MIN_FIELD = 20
) (
  input  logic [4:0] fn_field,
  output fn_kind_e   kind
);
  localparam logic [4:0] XFER_MIN = 5'(XFER_MIN_FIELD);

  always_comb begin
    kind = FK_OTHER;
    if (fn_field >= XFER_MIN) begin
      kind = FK_XFER;
    end else begin
      case (fn_field)
        5'd3, 5'd5, 5'd7, 5'd8, 5'd9: kind = FK_NOOP;
        default:                      kind = FK_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/dkc_offset_calc.sv
module dkc_offset_calc #(
  parameter int SECTORS      = 22,
  parameter int TRACKS       = 19,
  parameter int SECTOR_BYTES = 512,
  parameter int CYL_W        = 10,
  parameter int TRK_W        = 5,
  parameter int SEC_W        = 5,
  parameter int OFS_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic [CYL_W-1:0] cyl,
  input  logic [TRK_W-1:0] trk,
  input  logic [SEC_W-1:0] sec,
  output logic             start_q,
  output logic [OFS_W-1:0] offset_q
);
  localparam int SHIFT = $clog2(SECTOR_BYTES);
  localparam logic [OFS_W-1:0] TRK_K = OFS_W'(TRACKS);
  localparam logic [OFS_W-1:0] SEC_K = OFS_W'(SECTORS);

  logic [OFS_W-1:0] lin_sector;

  always_comb begin
    lin_sector = (OFS_W'(cyl) * TRK_K + OFS_W'(trk)) * SEC_K + OFS_W'(sec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      offset_q <= '0;
    end else begin
      start_q <= start_in;
      if (start_in) offset_q <= lin_sector << SHIFT;
    end
  end
endmodule

// File: rtl/dkc_read_view.sv
module dkc_read_view
  import dkc_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] regs [REG_COUNT],
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (sel <= SEL_LAST) rd_data = regs[sel];
    if (sel == SEL_CTRL)  rd_data = rd_data | CTRL_FORCE;
    if (sel == SEL_DSTAT) rd_data = rd_data | DSTAT_FORCE;
  end
endmodule

// File: rtl/dkc_regs.sv
module dkc_regs
  import dkc_pkg::*;
#(
  parameter int          SECTORS      = 22,
  parameter int          TRACKS       = 19,
  parameter int          SECTOR_BYTES = 512,
  parameter int          CYL_W        = 10,
  parameter int          OFS_W        = 32,
  parameter logic [2:0]  IRQ_LEVEL    = 3'd5,
  parameter logic [8:0]  IRQ_VECTOR   = 9'o254
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              xfer_done,
  output logic              xfer_start,
  output logic [OFS_W-1:0]  byte_offset,
  output logic [17:0]       dma_addr,
  output logic              irq_req,
  output logic [2:0]        irq_level,
  output logic [8:0]        irq_vector
);
  localparam int TRK_W = $clog2(TRACKS);
  localparam int SEC_W = $clog2(SECTORS);

  logic [WORD_W-1:0] regs_q [REG_COUNT];
  logic [WORD_W-1:0] regs_d [REG_COUNT];
  logic              irq_q;
  logic              fire_irq;
  logic              start_d;
  logic              wr_ctrl;
  fn_kind_e          kind;

  assign wr_ctrl = wr_en && (reg_sel == SEL_CTRL);

  dkc_func_decode u_dec (
    .fn_field (wr_data[CB_FNH:CB_FNL]),
    .kind     (kind)
  );

  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) regs_d[i] = regs_q[i];
    fire_irq = 1'b0;
    start_d  = 1'b0;
    if (wr_en && reg_sel <= SEL_LAST) regs_d[reg_sel] = wr_data;
    if (wr_ctrl) begin
      if (wr_data[CB_RDY]) regs_d[SEL_ATTN] = 16'd1;
      if (wr_data[CB_GO]) begin
        regs_d[SEL_CTRL] = wr_data & ~GO_CLEAR;
        if (kind == FK_NOOP) begin
          regs_d[SEL_CTRL][CB_RDY] = 1'b1;
          fire_irq = wr_data[CB_IE];
        end else if (kind == FK_XFER) begin
          start_d = 1'b1;
        end
      end
    end
    if (xfer_done) begin
      regs_d[SEL_WCNT] = '0;
      regs_d[SEL_CTRL][CB_RDY] = 1'b1;
      if (regs_d[SEL_CTRL][CB_IE]) fire_irq = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
      irq_q <= 1'b0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= regs_d[i];
      irq_q <= fire_irq;
    end
  end

  dkc_offset_calc #(
    .SECTORS      (SECTORS),
    .TRACKS       (TRACKS),
    .SECTOR_BYTES (SECTOR_BYTES),
    .CYL_W        (CYL_W),
    .TRK_W        (TRK_W),
    .SEC_W        (SEC_W),
    .OFS_W        (OFS_W)
  ) u_ofs (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_in (start_d),
    .cyl      (regs_q[SEL_CYL][CYL_W-1:0]),
    .trk      (regs_q[SEL_SECTRK][8+TRK_W-1:8]),
    .sec      (regs_q[SEL_SECTRK][SEC_W-1:0]),
    .start_q  (xfer_start),
    .offset_q (byte_offset)
  );

  dkc_read_view u_rd (
    .sel     (reg_sel),
    .regs    (regs_q),
    .rd_data (rd_data)
  );

  assign dma_addr   = {regs_q[SEL_CTRL][CB_A17], regs_q[SEL_CTRL][CB_A16], regs_q[SEL_BADDR]};
  assign irq_req    = irq_q;
  assign irq_level  = IRQ_LEVEL;
  assign irq_vector = IRQ_VECTOR;

  // R4: a control write carrying ready leaves attention at 1
  a_r4_attention_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctrl && wr_data[CB_RDY]) |-> regs_q[SEL_ATTN] == 16'd1);

  // R5: after a GO write no GO, function or transfer-error bit remains
  a_r5_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctrl && wr_data[CB_GO]) |->
      (!regs_q[SEL_CTRL][CB_GO] && !regs_q[SEL_CTRL][CB_TRE] &&
       regs_q[SEL_CTRL][CB_FNH:CB_FNL] == 5'd0));

  // R8: completion zeroes the word count and leaves ready set
  a_r8_done_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_done && !(wr_en && reg_sel == SEL_WCNT)) |->
      (regs_q[SEL_WCNT] == '0 && regs_q[SEL_CTRL][CB_RDY]));

  // R10: a request needs a cause seen with interrupt enable set
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past((wr_ctrl && wr_data[CB_GO] && wr_data[CB_IE]) ||
                      (xfer_done && (regs_q[SEL_CTRL][CB_IE] || (wr_ctrl && wr_data[CB_IE])))));

  // R7: a transfer start never comes with an interrupt from the same write
  a_r7_start_without_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !$past(xfer_done)) |-> !irq_req);
endmodule

// File: tb/dkc_regs_test.sv
module dkc_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        xfer_done = 1'b0;
  logic        xfer_start;
  logic [31:0] byte_offset;
  logic [17:0] dma_addr;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic [8:0]  irq_vector;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  dkc_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .xfer_done(xfer_done), .xfer_start(xfer_start),
    .byte_offset(byte_offset), .dma_addr(dma_addr), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  typedef struct packed {
    logic [4:0]  wsel;
    logic [15:0] wdat;
    logic [4:0]  rsel;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd3, 16'o1234, 5'd3, 16'o1234},   // R1 word count store
    '{5'd1, 16'h0001, 5'd1, 16'h11C1},   // R3 status forced bits
    '{5'd0, 16'h0040, 5'd2, 16'h0000},   // R4 no ready, attention kept
    '{5'd0, 16'h0080, 5'd2, 16'h0001},   // R4 ready sets attention
    '{5'd2, 16'h0000, 5'd2, 16'h0000},   // R1 attention writable
    '{5'd0, 16'h4047, 5'd0, 16'h00C0},   // R5 GO clears fn, GO, TRE
    '{5'd4, 16'hBEEF, 5'd4, 16'hBEEF},   // R1 bus address
    '{5'd0, 16'h0300, 5'd0, 16'h0380}    // R2 ready forced on read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] s, input logic [15:0] exp);
    reg_sel = s;
    #1;
    chk(tag, {16'd0, rd_data}, {16'd0, exp});
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd("R1 reset ctrl", 5'd0, 16'h0080);
    rd("R3 reset status", 5'd1, 16'h11C0);
    rd("R1 reset word count", 5'd3, 16'h0000);
    chk("R10 reset irq", {31'd0, irq_req}, 32'd0);
    chk("R7 reset start", {31'd0, xfer_start}, 32'd0);
    chk("R10 level", {29'd0, irq_level}, 32'd5);
    chk("R10 vector", {23'd0, irq_vector}, 32'o254);

    foreach (VECS[i]) begin
      wr(VECS[i].wsel, VECS[i].wdat);
      rd($sformatf("vector %0d R1..R5", i), VECS[i].rsel, VECS[i].exp);
    end

    // R9 DMA address from A17/A16 and bus address
    chk("R9 dma address", {14'd0, dma_addr}, 32'h3BEEF);

    // R1 plain storage and out-of-range select
    wr(5'd16, 16'hA5A5);
    rd("R1 storage 16", 5'd16, 16'hA5A5);
    wr(5'd20, 16'h1234);
    rd("R1 out of range", 5'd20, 16'h0000);

    // R6 housekeeping 006 with IE: one-cycle interrupt
    wr(5'd0, 16'h0047);
    chk("R6 noop irq", {31'd0, irq_req}, 32'd1);
    chk("R7 noop no start", {31'd0, xfer_start}, 32'd0);
    step;
    chk("R10 irq one cycle", {31'd0, irq_req}, 32'd0);

    // R6 housekeeping 022 without IE: no interrupt
    wr(5'd0, 16'h0013);
    chk("R10 no irq without enable", {31'd0, irq_req}, 32'd0);
    rd("R6 ctrl after 022", 5'd0, 16'h0080);

    // R7 code 046: neither housekeeping nor transfer
    wr(5'd0, 16'h0067);
    chk("R7 code 046 no start", {31'd0, xfer_start}, 32'd0);
    chk("R7 code 046 no irq", {31'd0, irq_req}, 32'd0);
    rd("R5 fn field cleared", 5'd0, 16'h00C0);

    // R11 transfer with geometry
    wr(5'd6, 16'd2);
    wr(5'd5, 16'h0305);
    wr(5'd3, 16'o100);
    wr(5'd0, 16'h0379);
    chk("R7 start strobe", {31'd0, xfer_start}, 32'd1);
    chk("R11 byte offset", byte_offset, 32'd464384);
    chk("R7 no irq on start", {31'd0, irq_req}, 32'd0);
    chk("R9 dma keeps A bits", {14'd0, dma_addr}, 32'h3BEEF);
    step;
    chk("R7 start one cycle", {31'd0, xfer_start}, 32'd0);

    // R8 completion
    xfer_done = 1'b1;
    step;
    xfer_done = 1'b0;
    chk("R8 done irq", {31'd0, irq_req}, 32'd1);
    rd("R8 word count zero", 5'd3, 16'h0000);
    step;
    chk("R10 done irq one cycle", {31'd0, irq_req}, 32'd0);

    // R7 lowest transfer code 050, IE off; R8 completion without enable
    wr(5'd0, 16'h0029);
    chk("R7 code 050 starts", {31'd0, xfer_start}, 32'd1);
    wr(5'd3, 16'd7);
    xfer_done = 1'b1;
    step;
    xfer_done = 1'b0;
    chk("R8 no irq without enable", {31'd0, irq_req}, 32'd0);
    rd("R8 word count cleared", 5'd3, 16'h0000);

    // R11 zero location gives zero offset
    wr(5'd6, 16'd0);
    wr(5'd5, 16'h0000);
    wr(5'd0, 16'h0071);
    chk("R11 zero offset", byte_offset, 32'd0);

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule